// File: doc/BRIEF.md
# Reloadable Timer and Event Counter

This block is a 16-bit up-counter that a processor programs and reads through a small 8-bit register port. A control byte picks one of three counting modes. In interval-timer mode the counter runs from an internal tick. In event mode it counts edges on an external pin. In pulse-width mode it times how long the external pin holds a chosen level. The internal tick comes from either the system clock divided by eight or an alternate slow clock. A power-of-two prescaler then divides that tick further.

When the counter is full and receives one more count, it does not wrap to zero. It reloads the value in a 16-bit preload register and keeps counting. On that overflow it pulses a wake-up output every time, and it pulses an interrupt request only when the interrupt enable input is high. Reading the upper count byte takes a snapshot of the lower byte, so the next read of the lower byte matches it even if the counter has moved on in between. In event mode the counter keeps counting while the system is powered down, so an external event can wake the system.

Top module: `reload_timer`

## Requirements
- R1: After reset the control byte, the counter, the preload value and the low-byte snapshot are all 0, and irq and wake are low.
- R2: Control bits [7:6] select the mode: 2'b10 interval timer, 2'b01 event counter, 2'b11 pulse-width measurement. 2'b00 never counts.
- R3: Control bit 4 is the run enable. While it is 0 the counter keeps its value.
- R4: In timer mode with control bit 5 at 0, the base tick is the system clock divided by 8. Control bits [2:0] hold p, and the base tick is further divided by 2^p. Once run is set, the dividers start from zero, so after k clocks the count has advanced by floor(k / (8 * 2^p)).
- R5: In timer mode with control bit 5 at 1, each high-to-low transition of altClk is a base tick. After synchronization, one count is made per falling edge when p = 0.
- R6: In event mode, control bit 3 = 0 counts rising edges of extIn and control bit 3 = 1 counts falling edges. extIn passes through a two-flop synchronizer first.
- R7: A count made at 16'hFFFF loads the preload value into the counter, and counting continues from there.
- R8: Each overflow gives a one-cycle irq pulse when intEn is 1 and no pulse when intEn is 0.
- R9: Each overflow gives a one-cycle wake pulse whatever the value of intEn.
- R10: While powerDown is 1, internal ticks stop, so timer and pulse-width modes do not count. Event mode keeps counting external edges.
- R11: Register map. Write address 0 is the control byte, 1 the preload low byte, 2 the preload high byte. Read address 0 returns the control byte, 2 the live count high byte, 1 the low-byte snapshot, and 3 returns 0. A read of address 2 copies the live low byte into the snapshot.
- R12: In pulse-width mode, while run is 1 the counter advances on internal ticks for as long as the synchronized extIn holds the level chosen by bit 3 (0: high, 1: low). When extIn leaves that level, run clears to 0.
- R13: A write to either preload byte while run is 0 also loads the whole updated preload value into the counter. The same write while run is 1 leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe; rdData is 0 when low |
| addr | input | 2 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data |
| altClk | input | 1 | Alternate internal count clock (asynchronous) |
| extIn | input | 1 | External event / pulse input (asynchronous) |
| intEn | input | 1 | Overflow interrupt enable |
| powerDown | input | 1 | System power-down indication |
| irq | output | 1 | Overflow interrupt request pulse |
| wake | output | 1 | Overflow wake-up pulse |

## Verification
Timer mode is run for a fixed 100-clock window at prescaler settings 0 and 2. The exact counts of 12 and 3 expose any slip in the divide-by-8 stage or the prescaler mask. Event mode uses sequences with different numbers of rising and falling edges, so a reversed edge select produces a different count. A preload near the top of the range drives overflows with intEn set and then cleared, which separates reload-from-preload from wrap-to-zero and irq from wake. A held pulse of known length, a carry from the low byte into the high byte between two reads, and a power-down window in each mode cover the measurement stop, the read snapshot and the gating of internal ticks.

// File: rtl/rtimer_pkg.sv
package rtimer_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_PULSE = 2'b11
  } mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic countTick;  // advance the counter by one
    logic stopLoad;   // preload write while stopped: copy preload into counter
  } strobe_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_LO   = 2'd1;
  localparam logic [1:0] ADDR_HI   = 2'd2;

  // control byte fields
  localparam int CB_MODE_HI = 7;
  localparam int CB_MODE_LO = 6;
  localparam int CB_SRC     = 5;
  localparam int CB_RUN     = 4;
  localparam int CB_EDGE    = 3;

endpackage

// File: rtl/rtimer_sync.sv
module rtimer_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/rtimer_ctrl.sv
module rtimer_ctrl
  import rtimer_pkg::*;
#(
  parameter int BUS_W       = 8,
  parameter int SYS_DIV_W   = 3,
  parameter int PSC_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       addr,
  input  logic [BUS_W-1:0] wrData,
  input  logic             altClk,
  input  logic             extIn,
  input  logic             powerDown,
  output logic [BUS_W-1:0] ctrlReg,
  output strobe_t          strobe
);

  localparam int PRE_W = (1 << PSC_W) - 1;

  mode_e            mode;
  logic             run;
  logic             edgeSel;
  logic             srcAlt;
  logic [PSC_W-1:0] psc;

  logic extS, extPrev, altS, altPrev;
  logic extRise, extFall, altFall;
  logic evtEdge, activeLvl, pulseEnd;
  logic gateOn;

  logic [SYS_DIV_W-1:0] sysDiv;
  logic [PRE_W-1:0]     preCnt;
  logic [PRE_W-1:0]     preMask;
  logic                 sysTick, altTick, baseTick, intTick;
  logic                 ctrlWrite;

  assign mode    = mode_e'(ctrlReg[CB_MODE_HI:CB_MODE_LO]);
  assign run     = ctrlReg[CB_RUN];
  assign edgeSel = ctrlReg[CB_EDGE];
  assign srcAlt  = ctrlReg[CB_SRC];
  assign psc     = ctrlReg[PSC_W-1:0];

  // input synchronizers
  rtimer_sync #(.STAGES(SYNC_STAGES)) u_syncExt (
    .clk(clk), .rstN(rstN), .din(extIn), .dout(extS)
  );
  rtimer_sync #(.STAGES(SYNC_STAGES)) u_syncAlt (
    .clk(clk), .rstN(rstN), .din(altClk), .dout(altS)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extPrev <= 1'b0;
      altPrev <= 1'b0;
    end else begin
      extPrev <= extS;
      altPrev <= altS;
    end
  end

  assign extRise   = extS & ~extPrev;
  assign extFall   = ~extS & extPrev;
  assign altFall   = ~altS & altPrev;
  assign evtEdge   = edgeSel ? extFall : extRise;
  assign activeLvl = (extS == ~edgeSel);
  assign pulseEnd  = edgeSel ? extRise : extFall;

  // internal tick gating: timer always, pulse mode only at active level
  assign gateOn = run && !powerDown &&
                  ((mode == MODE_TIMER) || ((mode == MODE_PULSE) && activeLvl));

  // system clock divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sysDiv <= '0;
    else if (!gateOn || srcAlt) sysDiv <= '0;
    else                       sysDiv <= sysDiv + 1'b1;
  end

  assign sysTick  = gateOn && !srcAlt && (sysDiv == {SYS_DIV_W{1'b1}});
  assign altTick  = gateOn && srcAlt && altFall;
  assign baseTick = sysTick || altTick;

  // power-of-two prescaler
  assign preMask = ~({PRE_W{1'b1}} << psc);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         preCnt <= '0;
    else if (!gateOn)  preCnt <= '0;
    else if (baseTick) preCnt <= preCnt + 1'b1;
  end

  assign intTick = baseTick && ((preCnt & preMask) == preMask);

  // control register
  assign ctrlWrite = wrEn && (addr == ADDR_CTRL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      ctrlReg <= '0;
    else if (ctrlWrite)
      ctrlReg <= wrData;
    else if (run && (mode == MODE_PULSE) && pulseEnd)
      ctrlReg[CB_RUN] <= 1'b0;
  end

  always_comb begin
    strobe.countTick = ((mode == MODE_EVENT) && run && evtEdge) ||
                       (((mode == MODE_TIMER) || (mode == MODE_PULSE)) && intTick);
    strobe.stopLoad  = wrEn && !run && ((addr == ADDR_LO) || (addr == ADDR_HI));
  end

  // R2: a halted mode never produces a count
  a_r2_off_no_tick: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_OFF) |-> !strobe.countTick);

  // R3: no count while the run enable is clear
  a_r3_stopped_no_tick: assert property (@(posedge clk) disable iff (!rstN)
    !run |-> !strobe.countTick);

  // R10: internal ticks are gated in power-down
  a_r10_pd_no_internal: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |-> !intTick);

  // R12: leaving the measured level clears the run enable
  a_r12_pulse_stop: assert property (@(posedge clk) disable iff (!rstN)
    (run && (mode == MODE_PULSE) && pulseEnd && !ctrlWrite) |=> !ctrlReg[CB_RUN]);

endmodule

// File: rtl/rtimer_datapath.sv
module rtimer_datapath
  import rtimer_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [1:0]       addr,
  input  logic [BUS_W-1:0] wrData,
  input  logic             intEn,
  input  logic [BUS_W-1:0] ctrlReg,
  input  strobe_t          strobe,
  output logic [BUS_W-1:0] rdData,
  output logic             irq,
  output logic             wake
);

  localparam int CNT_W = 2 * BUS_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] preload;
  logic [CNT_W-1:0] preNext;
  logic [BUS_W-1:0] lowBuf;
  logic             ovf;

  always_comb begin
    preNext = preload;
    if (wrEn && (addr == ADDR_LO)) preNext[BUS_W-1:0]     = wrData;
    if (wrEn && (addr == ADDR_HI)) preNext[CNT_W-1:BUS_W] = wrData;
  end

  assign ovf = strobe.countTick && !strobe.stopLoad && (count == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preload <= '0;
      count   <= '0;
    end else begin
      preload <= preNext;
      if (strobe.stopLoad)
        count <= preNext;
      else if (strobe.countTick)
        count <= (count == CNT_MAX) ? preload : count + 1'b1;
    end
  end

  // snapshot of the low byte taken on high-byte read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       lowBuf <= '0;
    else if (rdEn && addr == ADDR_HI) lowBuf <= count[BUS_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irq  <= 1'b0;
      wake <= 1'b0;
    end else begin
      irq  <= ovf && intEn;
      wake <= ovf;
    end
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      case (addr)
        ADDR_CTRL: rdData = ctrlReg;
        ADDR_LO:   rdData = lowBuf;
        ADDR_HI:   rdData = count[CNT_W-1:BUS_W];
        default:   rdData = '0;
      endcase
    end
  end

  // R3: without a count or load strobe the counter is stable
  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.countTick && !strobe.stopLoad) |=> $stable(count));

  // R7: overflow reloads from the preload register
  a_r7_reload: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.countTick && !strobe.stopLoad && count == CNT_MAX) |=> (count == $past(preload)));

  // R8: an interrupt pulse requires the enable
  a_r8_irq_needs_en: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(intEn));

  // R9: every interrupt pulse coincides with a wake pulse
  a_r9_irq_with_wake: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> wake);

  // R11: high-byte read captures the live low byte
  a_r11_snapshot: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_HI) |=> (lowBuf == $past(count[BUS_W-1:0])));

endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import rtimer_pkg::*;
#(
  parameter int BUS_W       = 8,
  parameter int SYS_DIV_W   = 3,
  parameter int PSC_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [1:0]       addr,
  input  logic [BUS_W-1:0] wrData,
  output logic [BUS_W-1:0] rdData,
  input  logic             altClk,
  input  logic             extIn,
  input  logic             intEn,
  input  logic             powerDown,
  output logic             irq,
  output logic             wake
);

  logic [BUS_W-1:0] ctrlReg;
  strobe_t          strobe;

  rtimer_ctrl #(
    .BUS_W(BUS_W), .SYS_DIV_W(SYS_DIV_W), .PSC_W(PSC_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .altClk(altClk), .extIn(extIn), .powerDown(powerDown),
    .ctrlReg(ctrlReg), .strobe(strobe)
  );

  rtimer_datapath #(.BUS_W(BUS_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .intEn(intEn), .ctrlReg(ctrlReg), .strobe(strobe),
    .rdData(rdData), .irq(irq), .wake(wake)
  );

endmodule

// File: tb/reload_timer_tb.sv
module reload_timer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int Q = CLK_PERIOD / 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0, rdEn = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       altClk = 1'b0, extIn = 1'b0, intEn = 1'b0, powerDown = 1'b0;
  logic       irq, wake;

  int checks = 0;
  int errors = 0;
  int irqCnt = 0;
  int wakeCnt = 0;

  logic [7:0] expQ[$];
  string      tagQ[$];

  reload_timer u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .altClk(altClk), .extIn(extIn),
    .intEn(intEn), .powerDown(powerDown), .irq(irq), .wake(wake)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: pops expected read data and compares at the falling edge
  always @(negedge clk) begin
    if (rstN && irq)  irqCnt++;
    if (rstN && wake) wakeCnt++;
    if (rdEn) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL unexpected read: actual %0h expected none", rdData);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if (rdData !== e) begin
          errors++;
          $display("FAIL %s: actual %0h expected %0h", t, rdData, e);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #Q;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    step(1);
    wrEn = 1'b1; addr = a; wrData = d;
    step(1);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
    step(1);
    expQ.push_back(e); tagQ.push_back(t);
    rdEn = 1'b1; addr = a;
    step(1);
    rdEn = 1'b0;
  endtask

  task automatic rdCount(input logic [15:0] e, input string t);
    rd(2'd2, e[15:8], t);
    rd(2'd1, e[7:0], t);
  endtask

  task automatic chk(input int act, input int exp, input string t);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic loadCount(input logic [15:0] v);
    wr(2'd1, v[7:0]);
    wr(2'd2, v[15:8]);
  endtask

  task automatic extPulse(input logic lvl);
    extIn = lvl; step(4);
  endtask

  task automatic finishRun;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step(2);

    // R1 reset state
    chk(irq, 0, "R1 irq");
    chk(wake, 0, "R1 wake");
    rd(2'd0, 8'h00, "R1 ctrl");
    rdCount(16'h0000, "R1 count");

    // R4 timer, sys/8, p=0 : 100 clocks -> 12
    wr(2'd0, 8'h90); step(98); wr(2'd0, 8'h80);
    rdCount(16'd12, "R4 p0");
    // R3 stopped: holds
    step(20);
    rdCount(16'd12, "R3 hold");

    // R13 stopped preload write loads counter; R4 p=2 -> 3
    loadCount(16'h0000);
    rdCount(16'h0000, "R13 stopped load");
    wr(2'd0, 8'h92); step(98); wr(2'd0, 8'h82);
    rdCount(16'd3, "R4 p2");

    // R2 mode 00 never counts
    loadCount(16'h0000);
    wr(2'd0, 8'h10); step(50); wr(2'd0, 8'h00);
    rdCount(16'h0000, "R2 off mode");

    // R6 rising edges: 3 rises, 2 falls; R13 running preload write ignored
    wr(2'd0, 8'h50);
    wr(2'd1, 8'h55);
    extPulse(1); extPulse(0); extPulse(1); extPulse(0); extPulse(1);
    wr(2'd0, 8'h40);
    rdCount(16'd3, "R6 rising / R13 running");
    // R6 falling: start high, 2 falls, 1 rise
    loadCount(16'h0000);
    extIn = 1'b1; step(4);
    wr(2'd0, 8'h58);
    extPulse(0); extPulse(1); extPulse(0);
    wr(2'd0, 8'h48);
    rdCount(16'd2, "R6 falling");

    // R7 R8 R9 overflow with intEn=1
    loadCount(16'hFFFD);
    intEn = 1'b1;
    wr(2'd0, 8'h50);
    repeat (4) begin extPulse(1); extPulse(0); end
    wr(2'd0, 8'h40);
    rdCount(16'hFFFE, "R7 reload");
    chk(irqCnt, 1, "R8 irq enabled");
    chk(wakeCnt, 1, "R9 wake");
    // intEn=0: overflow again, no irq, wake still
    intEn = 1'b0;
    wr(2'd0, 8'h50);
    repeat (2) begin extPulse(1); extPulse(0); end
    wr(2'd0, 8'h40);
    rdCount(16'hFFFD, "R7 reload 2");
    chk(irqCnt, 1, "R8 irq disabled");
    chk(wakeCnt, 2, "R9 wake no enable");

    // R11 coherent read across a carry
    loadCount(16'h00FE);
    wr(2'd0, 8'h50);
    extPulse(1); extPulse(0);
    rd(2'd2, 8'h00, "R11 high");
    extPulse(1); extPulse(0);
    rd(2'd1, 8'hFF, "R11 snapshot");
    rd(2'd2, 8'h01, "R11 high after carry");
    rd(2'd1, 8'h00, "R11 new snapshot");
    rd(2'd3, 8'h00, "R11 addr3");
    wr(2'd0, 8'h40);

    // R10 power-down: timer stops, event continues
    loadCount(16'h0000);
    powerDown = 1'b1;
    wr(2'd0, 8'h90); step(98); wr(2'd0, 8'h80);
    rdCount(16'h0000, "R10 timer pd");
    wr(2'd0, 8'h50);
    repeat (2) begin extPulse(1); extPulse(0); end
    wr(2'd0, 8'h40);
    rdCount(16'd2, "R10 event pd");
    powerDown = 1'b0;

    // R5 alternate clock: 4 falling edges
    loadCount(16'h0000);
    wr(2'd0, 8'hB0);
    repeat (4) begin altClk = 1'b1; step(3); altClk = 1'b0; step(3); end
    step(3);
    wr(2'd0, 8'hA0);
    rdCount(16'd4, "R5 alt clock");

    // R12 pulse-width: high level held 84 clocks -> 10, run cleared
    loadCount(16'h0000);
    extIn = 1'b0;
    wr(2'd0, 8'hD0);
    step(10);
    extIn = 1'b1; step(84);
    extIn = 1'b0; step(10);
    rd(2'd0, 8'hC0, "R12 run cleared");
    rdCount(16'd10, "R12 width");
    extIn = 1'b1; step(20); extIn = 1'b0; step(5);
    rdCount(16'd10, "R12 stopped after end");

    step(4);
    chk(expQ.size(), 0, "scoreboard drained");
    finishRun();
  end

endmodule